// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a bitstream into an SRAM-based programmable device over a one-bit serial link. A host pulses a start input together with a byte count. The block pulls the device's active-low program request low for a timed interval. It then requires the device's active-low status line to answer low, releases the program request, and waits a settle time. After that it polls until the device lets its status line go high, and gives up if this does not happen within a timeout.

Once the device is ready, the block takes bitstream bytes from the host over a valid/ready handshake. It shifts each byte out least significant bit first on a data pin, and a serial clock whose rising edge the device samples. When the last byte is out, the block waits for the device's configuration-complete input. It then issues a fixed burst of further clock pulses with the data pin low and reports success. Every delay is a cycle count computed from the system clock frequency, and a divider sets the serial clock half-period. Both device inputs pass through two-flop synchronizers before the sequencer uses them.

A cancel input ends any running sequence. The status output holds its final code until the next start.

Top module: `psconf_master`

## Requirements
- R1: After reset and whenever the block is not busy, prog_n_o is 1, sclk_o is 0, sdat_o is 0 and byte_ready_o is 0. The status codes are 0 idle (after reset only), 1 busy, 2 success, 3 status-not-asserted, 4 status-timeout, 5 done-missing and 6 aborted.
- R2: A start pulse while status_o is not 1 sets status_o to 1. It drives prog_n_o low for exactly ceil(CLK_HZ*PULSE_US/1e6) cycles (at least 1), with sclk_o low throughout. A start pulse while status_o is 1 has no effect.
- R3: If the synchronized stat_n_i is not 0 at the end of the program pulse, the block releases prog_n_o, issues no serial clock edge and sets status_o to 3.
- R4: After prog_n_o rises, the block waits ceil(CLK_HZ*SETTLE_US/1e6) cycles, then polls stat_n_i for up to ceil(CLK_HZ*TIMEOUT_US/1e6) cycles. If stat_n_i never reads 1, status_o becomes 4 exactly SETTLE+TIMEOUT cycles after prog_n_o rose.
- R5: The block accepts exactly nbytes_i bytes, latched at start, and each is shifted out least significant bit first as 8 rising edges of sclk_o. A count of 0 sends no data bits.
- R6: Each serial clock high phase lasts exactly DCLK_DIV cycles, and so does each low phase within a byte. sdat_o is stable on every rising edge of sclk_o and throughout every high phase.
- R7: byte_ready_o is 1 only after the device has released stat_n_i, while bytes remain and the shifter is idle. While waiting for a byte, sclk_o stays low.
- R8: If the synchronized cdone_i is 0 after the last byte, status_o becomes 5 and no trailing clock is issued.
- R9: If cdone_i is 1 after the last byte, exactly TRAIL_CLKS further rising edges of sclk_o follow with sdat_o at 0, and then status_o becomes 2.
- R10: cancel_i while status_o is 1 sets status_o to 6 in the next cycle, ahead of any other outcome. A byte handshaken in the same cycle is discarded and sends no clock edge. cancel_i while not busy is ignored.
- R11: A final status code (2 to 6) holds until the next start, and a new start after any ending runs a complete new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for a configuration run |
| cancel_i | input | 1 | Ends a running sequence with status 6 |
| nbytes_i | input | CNT_W | Bitstream length in bytes, sampled at start |
| byte_valid_i | input | 1 | Host presents a bitstream byte |
| byte_data_i | input | 8 | Bitstream byte |
| byte_ready_o | output | 1 | Block takes the byte this cycle |
| prog_n_o | output | 1 | Active-low program request to the device |
| sclk_o | output | 1 | Serial configuration clock |
| sdat_o | output | 1 | Serial configuration data |
| stat_n_i | input | 1 | Device status, active low, asynchronous |
| cdone_i | input | 1 | Device configuration complete, asynchronous |
| status_o | output | 3 | Status code as listed in R1 |

## Verification
A host cancel and a byte handshake can fall in the same cycle, because byte_ready_o does not look at cancel_i. The bench raises cancel_i in exactly the cycle it sees byte_ready_o high for the second byte of a four-byte load. The cancel must win: status_o must read 6, the device model must have counted exactly the 8 bits of the first byte, and all device pins must be back at their idle levels. A second collision is the timeout expiring while polling. There the bench counts the cycles from the program pulse's release to the status change against the arithmetic total.

// File: rtl/psconf_pkg.sv
package psconf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_BUSY       = 3'd1,
        ST_OK         = 3'd2,
        ST_ERR_NOSTAT = 3'd3,
        ST_ERR_TMO    = 3'd4,
        ST_ERR_NODONE = 3'd5,
        ST_ERR_ABORT  = 3'd6
    } cfg_status_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PULSE,
        PH_SETTLE,
        PH_POLL,
        PH_DATA,
        PH_CHECK,
        PH_TRAIL
    } cfg_phase_e;

    // Microseconds to clock cycles, rounded up, never below one cycle.
    function automatic int unsigned us_to_cycles(longint unsigned hz, longint unsigned us);
        longint unsigned c;
        c = (hz * us + 64'd999_999) / 64'd1_000_000;
        if (c == 64'd0) c = 64'd1;
        return c[31:0];
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psconf_sync.sv
module psconf_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                sync_q <= RST_VAL[i];
            end else begin
                meta_q <= d_i[i];
                sync_q <= meta_q;
            end
        end
        assign q_o[i] = sync_q;
    end
endmodule

// File: rtl/psconf_shifter.sv
module psconf_shifter #(
    parameter int unsigned DCLK_DIV   = 2,
    parameter int unsigned TRAIL_CLKS = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    input  logic       trail_i,
    output logic       idle_o,
    output logic       sclk_o,
    output logic       sdat_o
);
    import psconf_pkg::*;

    localparam int unsigned DIV_W = (DCLK_DIV > 1) ? $clog2(DCLK_DIV) : 1;
    localparam int unsigned BC_W  = $clog2(max_u(8, TRAIL_CLKS) + 1);

    typedef struct packed {
        logic             busy;
        logic             phase;   // 0: clock low, 1: clock high
        logic [DIV_W-1:0] div;
        logic [BC_W-1:0]  cnt;
        logic [7:0]       sh;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (clr_i) begin
            shf_d = '0;
        end else if (!shf_q.busy) begin
            if (load_i) begin
                shf_d.busy  = 1'b1;
                shf_d.phase = 1'b0;
                shf_d.div   = '0;
                shf_d.cnt   = BC_W'(8);
                shf_d.sh    = byte_i;
            end else if (trail_i) begin
                shf_d.busy  = 1'b1;
                shf_d.phase = 1'b0;
                shf_d.div   = '0;
                shf_d.cnt   = BC_W'(TRAIL_CLKS);
                shf_d.sh    = 8'h00;
            end
        end else if (shf_q.div == DIV_W'(DCLK_DIV - 1)) begin
            shf_d.div = '0;
            if (!shf_q.phase) begin
                shf_d.phase = 1'b1;
            end else begin
                shf_d.phase = 1'b0;
                shf_d.sh    = {1'b0, shf_q.sh[7:1]};
                shf_d.cnt   = shf_q.cnt - BC_W'(1);
                if (shf_q.cnt == BC_W'(1)) shf_d.busy = 1'b0;
            end
        end else begin
            shf_d.div = shf_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign idle_o = !shf_q.busy;
    assign sclk_o = shf_q.busy & shf_q.phase;
    assign sdat_o = shf_q.sh[0];
endmodule

// File: rtl/psconf_master.sv
module psconf_master #(
    parameter int unsigned CLK_HZ     = 125_000_000,
    parameter int unsigned PULSE_US   = 2,
    parameter int unsigned SETTLE_US  = 2,
    parameter int unsigned TIMEOUT_US = 100_000,
    parameter int unsigned DCLK_DIV   = 2,
    parameter int unsigned TRAIL_CLKS = 12,
    parameter int unsigned CNT_W      = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cancel_i,
    input  logic [CNT_W-1:0] nbytes_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_data_i,
    output logic             byte_ready_o,
    output logic             prog_n_o,
    output logic             sclk_o,
    output logic             sdat_o,
    input  logic             stat_n_i,
    input  logic             cdone_i,
    output logic [2:0]       status_o
);
    import psconf_pkg::*;

    localparam int unsigned PULSE_CYC  = us_to_cycles(CLK_HZ, PULSE_US);
    localparam int unsigned SETTLE_CYC = us_to_cycles(CLK_HZ, SETTLE_US);
    localparam int unsigned TMO_CYC    = us_to_cycles(CLK_HZ, TIMEOUT_US);
    localparam int unsigned SYNC_WAIT  = 2;
    localparam int unsigned TMR_MAX    = max_u(max_u(PULSE_CYC, SETTLE_CYC), max_u(TMO_CYC, SYNC_WAIT));
    localparam int unsigned TMR_W      = $clog2(TMR_MAX + 1);

    typedef struct packed {
        cfg_phase_e       phase;
        logic [TMR_W-1:0] tmr;
        logic [CNT_W-1:0] rem;
        cfg_status_e      status;
        logic             prog_n;
    } ctl_t;

    localparam ctl_t CTL_RST = '{phase: PH_IDLE, tmr: '0, rem: '0,
                                 status: ST_IDLE, prog_n: 1'b1};

    ctl_t ctl_d, ctl_q;

    logic [1:0] dev_sync;
    logic       stat_n_s, cdone_s;
    logic       shf_idle, shf_load, shf_trail, shf_clr;
    logic       ready;

    // bit 0: device status (idles released, high); bit 1: completion flag
    psconf_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cdone_i, stat_n_i}),
        .q_o   (dev_sync)
    );
    assign stat_n_s = dev_sync[0];
    assign cdone_s  = dev_sync[1];

    psconf_shifter #(.DCLK_DIV(DCLK_DIV), .TRAIL_CLKS(TRAIL_CLKS)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (shf_clr),
        .load_i  (shf_load),
        .byte_i  (byte_data_i),
        .trail_i (shf_trail),
        .idle_o  (shf_idle),
        .sclk_o  (sclk_o),
        .sdat_o  (sdat_o)
    );

    assign ready = (ctl_q.phase == PH_DATA) && shf_idle && (ctl_q.rem != '0);

    always_comb begin
        ctl_d     = ctl_q;
        shf_load  = 1'b0;
        shf_trail = 1'b0;
        shf_clr   = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    ctl_d.phase  = PH_PULSE;
                    ctl_d.tmr    = '0;
                    ctl_d.rem    = nbytes_i;
                    ctl_d.status = ST_BUSY;
                    ctl_d.prog_n = 1'b0;
                end
            end
            PH_PULSE: begin
                if (ctl_q.tmr == TMR_W'(PULSE_CYC - 1)) begin
                    ctl_d.tmr    = '0;
                    ctl_d.prog_n = 1'b1;
                    if (!stat_n_s) begin
                        ctl_d.phase = PH_SETTLE;
                    end else begin
                        ctl_d.phase  = PH_IDLE;
                        ctl_d.status = ST_ERR_NOSTAT;
                    end
                end else begin
                    ctl_d.tmr = ctl_q.tmr + TMR_W'(1);
                end
            end
            PH_SETTLE: begin
                if (ctl_q.tmr == TMR_W'(SETTLE_CYC - 1)) begin
                    ctl_d.tmr   = '0;
                    ctl_d.phase = PH_POLL;
                end else begin
                    ctl_d.tmr = ctl_q.tmr + TMR_W'(1);
                end
            end
            PH_POLL: begin
                if (stat_n_s) begin
                    ctl_d.tmr   = '0;
                    ctl_d.phase = PH_DATA;
                end else if (ctl_q.tmr == TMR_W'(TMO_CYC - 1)) begin
                    ctl_d.tmr    = '0;
                    ctl_d.phase  = PH_IDLE;
                    ctl_d.status = ST_ERR_TMO;
                end else begin
                    ctl_d.tmr = ctl_q.tmr + TMR_W'(1);
                end
            end
            PH_DATA: begin
                if (ready && byte_valid_i) begin
                    shf_load  = 1'b1;
                    ctl_d.rem = ctl_q.rem - CNT_W'(1);
                end else if ((ctl_q.rem == '0) && shf_idle) begin
                    ctl_d.tmr   = '0;
                    ctl_d.phase = PH_CHECK;
                end
            end
            PH_CHECK: begin
                // give the completion flag time to cross the synchronizer
                if (ctl_q.tmr == TMR_W'(SYNC_WAIT - 1)) begin
                    ctl_d.tmr = '0;
                    if (cdone_s) begin
                        shf_trail   = 1'b1;
                        ctl_d.phase = PH_TRAIL;
                    end else begin
                        ctl_d.phase  = PH_IDLE;
                        ctl_d.status = ST_ERR_NODONE;
                    end
                end else begin
                    ctl_d.tmr = ctl_q.tmr + TMR_W'(1);
                end
            end
            PH_TRAIL: begin
                if (shf_idle) begin
                    ctl_d.phase  = PH_IDLE;
                    ctl_d.status = ST_OK;
                end
            end
            default: ctl_d = CTL_RST;
        endcase

        // a host cancel outranks every other outcome of this cycle
        if (cancel_i && (ctl_q.phase != PH_IDLE)) begin
            ctl_d.phase  = PH_IDLE;
            ctl_d.tmr    = '0;
            ctl_d.rem    = '0;
            ctl_d.status = ST_ERR_ABORT;
            ctl_d.prog_n = 1'b1;
            shf_load     = 1'b0;
            shf_trail    = 1'b0;
            shf_clr      = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign byte_ready_o = ready;
    assign prog_n_o     = ctl_q.prog_n;
    assign status_o     = ctl_q.status;
endmodule

// File: rtl/psconf_master_chk.sv
module psconf_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       cancel_i,
    input logic       byte_ready_o,
    input logic       prog_n_o,
    input logic       sclk_o,
    input logic       sdat_o,
    input logic [2:0] status_o
);
    AST_QUIET_WHEN_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 3'd1) |-> (prog_n_o && !sclk_o && !sdat_o && !byte_ready_o)); // R1

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && status_o != 3'd1 && !cancel_i) |=> (status_o == 3'd1)); // R2

    AST_PULSE_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> (!sclk_o && !byte_ready_o)); // R2

    AST_SETUP_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(sdat_o)); // R6

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdat_o)); // R6

    AST_READY_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> !sclk_o); // R7

    AST_CANCEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_i && status_o == 3'd1) |=> (status_o == 3'd6)); // R10

    AST_FINAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o >= 3'd2 && !start_i) |=> $stable(status_o)); // R11
endmodule

bind psconf_master psconf_master_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cancel_i     (cancel_i),
    .byte_ready_o (byte_ready_o),
    .prog_n_o     (prog_n_o),
    .sclk_o       (sclk_o),
    .sdat_o       (sdat_o),
    .status_o     (status_o)
);

// File: tb/psconf_master_tb.sv
`timescale 1ns/1ps
module psconf_master_tb;
    localparam int unsigned CLK_HZ = 125_000_000;
    localparam int unsigned P_US   = 2;
    localparam int unsigned S_US   = 1;
    localparam int unsigned T_US   = 16;
    localparam int unsigned DIV    = 2;
    localparam int unsigned TRAIL  = 12;
    localparam int unsigned CW     = 12;
    localparam int PULSE_E  = (CLK_HZ / 1_000_000) * P_US;
    localparam int SETTLE_E = (CLK_HZ / 1_000_000) * S_US;
    localparam int TMO_E    = (CLK_HZ / 1_000_000) * T_US;
    localparam int REL_DLY  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, cancel_i = 1'b0;
    logic [CW-1:0] nbytes_i = '0;
    logic byte_valid_i = 1'b0;
    logic [7:0] byte_data_i = 8'h00;
    logic byte_ready_o, prog_n_o, sclk_o, sdat_o;
    logic stat_n_i = 1'b1, cdone_i = 1'b0;
    logic [2:0] status_o;

    always #4 clk = ~clk;

    psconf_master #(.CLK_HZ(CLK_HZ), .PULSE_US(P_US), .SETTLE_US(S_US), .TIMEOUT_US(T_US),
                    .DCLK_DIV(DIV), .TRAIL_CLKS(TRAIL), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cancel_i(cancel_i),
        .nbytes_i(nbytes_i), .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
        .byte_ready_o(byte_ready_o), .prog_n_o(prog_n_o), .sclk_o(sclk_o), .sdat_o(sdat_o),
        .stat_n_i(stat_n_i), .cdone_i(cdone_i), .status_o(status_o));

    int tests = 0, fails = 0;
    logic [7:0] tx_mem [0:319];
    logic [7:0] rx_mem [0:319];

    // device model: 0 normal, 1 status never asserted, 2 status never released
    int mdl_mode = 0;
    int rel_cnt = 0;
    bit cdone_en = 1'b1;
    int exp_bits = 0;
    int rx_bits = 0, trail_ones = 0;
    int hi_w = 0, bad_hi = 0, viol = 0;
    int low_run = 0, last_low = 0, hi_run = 0;

    always @(negedge clk) begin
        if (!prog_n_o) begin
            rel_cnt  <= 0;
            stat_n_i <= (mdl_mode == 1);
        end else if (rel_cnt < REL_DLY) begin
            rel_cnt <= rel_cnt + 1;
        end else if (mdl_mode != 2) begin
            stat_n_i <= 1'b1;
        end
        cdone_i <= cdone_en && (rx_bits >= exp_bits);
    end

    // receiver and pin monitors
    logic sclk_prev = 1'b0;
    always @(negedge clk) begin
        if (start_i && status_o != 3'd1) begin
            rx_bits    = 0;
            trail_ones = 0;
        end
        if (sclk_o && !sclk_prev) begin
            rx_mem[rx_bits >> 3][rx_bits & 7] = sdat_o;
            if (rx_bits >= exp_bits && sdat_o) trail_ones++;
            rx_bits++;
        end
        sclk_prev = sclk_o;
        if (sclk_o) hi_w++;
        else if (hi_w > 0) begin
            if (hi_w != DIV) bad_hi++;
            hi_w = 0;
        end
        if (byte_ready_o && (sclk_o || !prog_n_o)) viol++;
        if (!prog_n_o) low_run++;
        else if (low_run > 0) begin
            last_low = low_run;
            low_run  = 0;
        end
        if (!prog_n_o) hi_run = 0;
        else if (status_o == 3'd1) hi_run++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_end();
        int g = 0;
        while (status_o == 3'd1 && g < 60000) begin
            @(negedge clk);
            g++;
        end
        @(negedge clk);
    endtask

    // start a load of n bytes; cancel together with the handshake of byte cancel_idx
    task automatic run_load(input int n, input int cancel_idx);
        int idx = 0;
        int g = 0;
        exp_bits = 8 * n;
        tick();
        nbytes_i = CW'(n);
        start_i  = 1'b1;
        tick();
        start_i = 1'b0;
        repeat (10) tick();
        start_i = 1'b1;              // ignored: block is busy (R2)
        tick();
        start_i = 1'b0;
        byte_valid_i = (n > 0);
        byte_data_i  = tx_mem[0];
        while (idx < n && g < 60000) begin
            @(negedge clk);
            g++;
            if (status_o != 3'd1) break;
            if (byte_ready_o) begin
                if (idx == cancel_idx) cancel_i = 1'b1;
                tick();
                cancel_i = 1'b0;
                idx++;
                byte_data_i = tx_mem[idx];
                if (idx >= n) byte_valid_i = 1'b0;
            end
        end
        byte_valid_i = 1'b0;
        wait_end();
    endtask

    function automatic int byte_errs(input int n);
        int e = 0;
        for (int i = 0; i < n; i++)
            if (rx_mem[i] !== tx_mem[i]) e++;
        return e;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 prog_n idle", int'(prog_n_o), 1);
        chk("R1 sclk idle", int'(sclk_o), 0);
        chk("R1 sdat idle", int'(sdat_o), 0);
        chk("R1 ready idle", int'(byte_ready_o), 0);
        chk("R1 status idle", int'(status_o), 0);

        tick();
        cancel_i = 1'b1;
        tick();
        cancel_i = 1'b0;
        @(negedge clk);
        chk("R10 cancel while idle ignored", int'(status_o), 0);

        // basic load of three bytes
        tx_mem[0] = 8'h3C; tx_mem[1] = 8'h81; tx_mem[2] = 8'hE7;
        run_load(3, -1);
        chk("R2 program pulse width", last_low, PULSE_E);
        chk("R9 success code", int'(status_o), 2);
        chk("R5 three byte content", byte_errs(3), 0);
        chk("R9 data plus trailing edges", rx_bits, 24 + TRAIL);
        chk("R9 trailing data low", trail_ones, 0);
        chk("R1 quiet after success", int'({prog_n_o, sclk_o, sdat_o, byte_ready_o}), 8);
        repeat (40) @(negedge clk);
        chk("R11 success held", int'(status_o), 2);

        // every byte value in one load
        for (int i = 0; i < 256; i++) tx_mem[i] = 8'(i);
        run_load(256, -1);
        chk("R5 all byte values", byte_errs(256), 0);
        chk("R5 edge count full sweep", rx_bits, 8 * 256 + TRAIL);
        chk("R9 full sweep status", int'(status_o), 2);

        // single-byte patterns
        for (int p = 0; p < 6; p++) begin
            tx_mem[0] = (p == 0) ? 8'h01 : (p == 1) ? 8'h80 : (p == 2) ? 8'hFF :
                        (p == 3) ? 8'h00 : (p == 4) ? 8'hA5 : 8'h5A;
            run_load(1, -1);
            chk("R5 single byte pattern", int'(rx_mem[0]), int'(tx_mem[0]));
        end

        // zero length
        run_load(0, -1);
        chk("R5 zero bytes only trailing", rx_bits, TRAIL);
        chk("R9 zero bytes success", int'(status_o), 2);

        chk("R6 high phase width", bad_hi, 0);
        chk("R7 ready outside window", viol, 0);

        // status never asserted
        mdl_mode = 1;
        run_load(2, -1);
        chk("R3 status-not-asserted code", int'(status_o), 3);
        chk("R3 no clock edges", rx_bits, 0);
        chk("R3 program released", int'(prog_n_o), 1);
        mdl_mode = 0;
        repeat (REL_DLY + 5) @(negedge clk);

        // status never released
        mdl_mode = 2;
        run_load(2, -1);
        chk("R4 timeout code", int'(status_o), 4);
        chk("R4 timeout instant", hi_run, SETTLE_E + TMO_E);
        chk("R4 no clock edges", rx_bits, 0);
        mdl_mode = 0;
        repeat (REL_DLY + 5) @(negedge clk);

        // completion flag missing
        cdone_en = 1'b0;
        tx_mem[0] = 8'h12; tx_mem[1] = 8'h34;
        run_load(2, -1);
        chk("R8 done-missing code", int'(status_o), 5);
        chk("R8 no trailing edges", rx_bits, 16);
        cdone_en = 1'b1;

        // cancel in the same cycle as the second byte handshake
        run_load(4, 1);
        chk("R10 abort code", int'(status_o), 6);
        chk("R10 coincident byte discarded", rx_bits, 8);
        chk("R10 pins idle after abort", int'({prog_n_o, sclk_o, sdat_o}), 4);

        // cancel during the program pulse
        tick();
        nbytes_i = CW'(1);
        start_i  = 1'b1;
        tick();
        start_i = 1'b0;
        repeat (20) tick();
        cancel_i = 1'b1;
        tick();
        cancel_i = 1'b0;
        @(negedge clk);
        chk("R10 abort during pulse", int'(status_o), 6);
        chk("R10 program released", int'(prog_n_o), 1);
        repeat (REL_DLY + 5) @(negedge clk);

        // restart after an abort
        tx_mem[0] = 8'hC3; tx_mem[1] = 8'h96;
        run_load(2, -1);
        chk("R11 restart status", int'(status_o), 2);
        chk("R11 restart content", byte_errs(2), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired status=%0d expected=end of run", status_o);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule